// File: doc/BRIEF.md
# Masked I/O Cycle Trap Unit

This block observes a stream of I/O bus cycles and compares every sampled cycle against a small bank of programmable trap entries. An entry names a dword-aligned I/O address. It can also treat the low six dword address bits as wildcards, demand a given set of active-high byte enables with per-lane wildcards, and select reads, writes or both. When an enabled entry accepts a cycle, the unit raises a single-clock trap request for the system-management interrupt logic. It also records which entry fired, together with the address, byte enables and direction of the cycle that caused it.

Software sets up the entries through a 32-bit register port. Each 64-bit entry is reached as two dword halves. Bus completion, retry and the interrupt controller are handled elsewhere. The trap request and the captured cycle fields are the only results.

Top module: `io_trap_unit`

## Requirements
- R1: After reset every entry reads as zero on both halves, and no trap request is raised.
- R2: Register word index 2n is the low half (bits 31:0) of entry n, and index 2n+1 is its high half (bits 63:32). Only low-half bits 0, 15:2 and 23:18 and high-half bits 7:0 and 17:16 (entry bits 39:32 and 49:48) store data. All other bits read as zero and discard writes. Writes take effect on the clock edge where reg_wr_en is high, and reads are combinational from reg_addr.
- R3: An entry whose bit 0 (enable) is clear never produces a trap, whatever the cycle.
- R4: Entry bits 15:2 are compared with cycle address bits 15:2. Cycle address bits 1:0 take no part in the match.
- R5: Each set bit k of entry bits 23:18 makes cycle address bit k+2 (bits 7:2) match regardless of its value.
- R6: Entry bits 35:32 give the expected byte enables, lane 0 in bit 32. A set bit in 39:36 makes the corresponding lane match regardless.
- R7: With entry bit 49 clear, only reads match when bit 48 is 1 and only writes match when it is 0. With bit 49 set, both directions match.
- R8: A cycle is evaluated only on a clock edge where cyc_valid is high. A matching cycle raises trap_req for exactly the following clock cycle.
- R9: When several entries match the same cycle, trap_idx reports the lowest-numbered one.
- R10: On a trap the unit captures the entry index, the full 16-bit cycle address, the byte enables and the direction. These outputs hold their values until the next trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register dword index (entry*2 + half) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| cyc_valid | input | 1 | Observed I/O cycle is present this clock |
| cyc_addr | input | 16 | I/O cycle byte address |
| cyc_be | input | 4 | I/O cycle active-high byte enables |
| cyc_is_read | input | 1 | 1 for a read cycle, 0 for a write |
| trap_req | output | 1 | One-clock trap / interrupt request |
| trap_idx | output | 2 | Index of the entry that fired |
| trap_addr | output | 16 | Captured cycle address |
| trap_be | output | 4 | Captured cycle byte enables |
| trap_is_read | output | 1 | Captured cycle direction |

## Verification
The assertions assume that cyc_valid is low or has settled before each rising edge. They also assume that the entry contents seen by the comparators are the register values before any write on the same edge, so a trap traces back to the entries of the previous clock. The bench changes cycle and register inputs only at falling edges and never overlaps a register write with a sampled cycle. The expected result of each evaluated cycle therefore depends only on the entry values already written. Random cycles are drawn near the programmed entry addresses, so both hits and misses occur often.

// File: rtl/io_trap_pkg.sv
package io_trap_pkg;

  localparam int ENTRY_W = 64;
  localparam int HALF_W  = 32;
  localparam int IO_AW   = 16;
  localparam int DW_W    = IO_AW - 2;
  localparam int AM_W    = 6;
  localparam int BE_W    = 4;

  // storable bits of each half; everything else is reserved
  localparam logic [HALF_W-1:0] LO_KEEP = 32'h00FC_FFFD;
  localparam logic [HALF_W-1:0] HI_KEEP = 32'h0003_00FF;

  typedef struct packed {
    logic            rw_any;
    logic            rw_is_read;
    logic [BE_W-1:0] be_mask;
    logic [BE_W-1:0] be_want;
    logic [AM_W-1:0] am;
    logic [DW_W-1:0] dw_addr;
    logic            en;
  } trap_entry_t;

  function automatic logic [DW_W-1:0] addr_care(trap_entry_t e);
    return ~{{(DW_W-AM_W){1'b0}}, e.am};
  endfunction

  function automatic logic entry_matches(trap_entry_t e, logic [DW_W-1:0] dw,
                                         logic [BE_W-1:0] be, logic rd);
    logic a_ok, b_ok, d_ok;
    a_ok = (((dw ^ e.dw_addr) & addr_care(e)) == '0);
    b_ok = (((be ^ e.be_want) & ~e.be_mask) == '0);
    d_ok = e.rw_any || (e.rw_is_read == rd);
    return e.en && a_ok && b_ok && d_ok;
  endfunction

endpackage

// File: rtl/io_trap_regs.sv
module io_trap_regs
  import io_trap_pkg::*;
#(
  parameter int N_ENTRY = 4,
  localparam int IDX_W  = $clog2(N_ENTRY),
  localparam int REG_AW = IDX_W + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [REG_AW-1:0]              addr,
  input  logic [HALF_W-1:0]              wdata,
  output logic [HALF_W-1:0]              rdata,
  output trap_entry_t [N_ENTRY-1:0]      ent_o
);

  logic [N_ENTRY-1:0][ENTRY_W-1:0] store_q;
  logic [IDX_W-1:0]                sel_idx;
  logic [ENTRY_W-1:0]              sel_ent;

  assign sel_idx = addr[REG_AW-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < N_ENTRY; i++) begin
        if (sel_idx == IDX_W'(i)) begin
          if (addr[0]) store_q[i][ENTRY_W-1:HALF_W] <= wdata & HI_KEEP;
          else         store_q[i][HALF_W-1:0]       <= wdata & LO_KEEP;
        end
      end
    end
  end

  always_comb begin
    sel_ent = store_q[sel_idx];
    rdata   = addr[0] ? sel_ent[ENTRY_W-1:HALF_W] : sel_ent[HALF_W-1:0];
  end

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_ent
    assign ent_o[g].en         = store_q[g][0];
    assign ent_o[g].dw_addr    = store_q[g][15:2];
    assign ent_o[g].am         = store_q[g][23:18];
    assign ent_o[g].be_want    = store_q[g][35:32];
    assign ent_o[g].be_mask    = store_q[g][39:36];
    assign ent_o[g].rw_is_read = store_q[g][48];
    assign ent_o[g].rw_any     = store_q[g][49];
  end

endmodule

// File: rtl/io_trap_match.sv
module io_trap_match
  import io_trap_pkg::*;
#(
  parameter int N_ENTRY = 4
) (
  input  trap_entry_t [N_ENTRY-1:0] ent_i,
  input  logic [DW_W-1:0]           cyc_dw,
  input  logic [BE_W-1:0]           cyc_be,
  input  logic                      cyc_rd,
  output logic [N_ENTRY-1:0]        hit_o
);

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_cmp
    assign hit_o[g] = entry_matches(ent_i[g], cyc_dw, cyc_be, cyc_rd);
  end

endmodule

// File: rtl/io_trap_report.sv
module io_trap_report
  import io_trap_pkg::*;
#(
  parameter int N_ENTRY = 4,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_valid,
  input  logic [N_ENTRY-1:0] hit_i,
  input  logic [IO_AW-1:0]   cyc_addr,
  input  logic [BE_W-1:0]    cyc_be,
  input  logic               cyc_rd,
  output logic               trap_req,
  output logic [IDX_W-1:0]   trap_idx,
  output logic [IO_AW-1:0]   trap_addr,
  output logic [BE_W-1:0]    trap_be,
  output logic               trap_is_read
);

  function automatic logic [IDX_W-1:0] lowest_set(logic [N_ENTRY-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_ENTRY - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic take;
  assign take = cyc_valid && (|hit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_req     <= 1'b0;
      trap_idx     <= '0;
      trap_addr    <= '0;
      trap_be      <= '0;
      trap_is_read <= 1'b0;
    end else begin
      trap_req <= take;
      if (take) begin
        trap_idx     <= lowest_set(hit_i);
        trap_addr    <= cyc_addr;
        trap_be      <= cyc_be;
        trap_is_read <= cyc_rd;
      end
    end
  end

endmodule

// File: rtl/io_trap_unit.sv
module io_trap_unit
  import io_trap_pkg::*;
#(
  parameter int N_ENTRY = 4,
  localparam int IDX_W  = $clog2(N_ENTRY),
  localparam int REG_AW = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              cyc_valid,
  input  logic [15:0]       cyc_addr,
  input  logic [3:0]        cyc_be,
  input  logic              cyc_is_read,
  output logic              trap_req,
  output logic [IDX_W-1:0]  trap_idx,
  output logic [15:0]       trap_addr,
  output logic [3:0]        trap_be,
  output logic              trap_is_read
);

  trap_entry_t [N_ENTRY-1:0] entries;
  logic [N_ENTRY-1:0]        entry_hit;
  logic [N_ENTRY-1:0]        entry_en;
  logic                      any_enabled;

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_en
    assign entry_en[g] = entries[g].en;
  end
  assign any_enabled = |entry_en;

  io_trap_regs #(.N_ENTRY(N_ENTRY)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ent_o (entries)
  );

  io_trap_match #(.N_ENTRY(N_ENTRY)) u_match (
    .ent_i  (entries),
    .cyc_dw (cyc_addr[15:2]),
    .cyc_be (cyc_be),
    .cyc_rd (cyc_is_read),
    .hit_o  (entry_hit)
  );

  io_trap_report #(.N_ENTRY(N_ENTRY)) u_report (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_valid    (cyc_valid),
    .hit_i        (entry_hit),
    .cyc_addr     (cyc_addr),
    .cyc_be       (cyc_be),
    .cyc_rd       (cyc_is_read),
    .trap_req     (trap_req),
    .trap_idx     (trap_idx),
    .trap_addr    (trap_addr),
    .trap_be      (trap_be),
    .trap_is_read (trap_is_read)
  );

endmodule

// File: rtl/io_trap_checker.sv
module io_trap_checker
  import io_trap_pkg::*;
#(
  parameter int N_ENTRY = 4,
  localparam int IDX_W  = $clog2(N_ENTRY),
  localparam int REG_AW = IDX_W + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cyc_valid,
  input logic [REG_AW-1:0]  reg_addr,
  input logic [31:0]        reg_rdata,
  input logic [N_ENTRY-1:0] entry_hit,
  input logic               any_enabled,
  input logic               trap_req,
  input logic [IDX_W-1:0]   trap_idx,
  input logic [15:0]        trap_addr,
  input logic [3:0]         trap_be,
  input logic               trap_is_read
);

  logic [N_ENTRY-1:0] below_idx;
  logic [31:0]        keep_now;
  assign below_idx = (N_ENTRY'(1) << trap_idx) - N_ENTRY'(1);
  assign keep_now  = reg_addr[0] ? HI_KEEP : LO_KEEP;

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~keep_now) == 32'h0);

  p_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(any_enabled));

  p_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(cyc_valid));

  p_hit_fires_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && (|entry_hit)) |=> trap_req);

  p_lowest_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ((($past(entry_hit) >> trap_idx) & N_ENTRY'(1)) != '0)
                 && (($past(entry_hit) & below_idx) == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> ($stable(trap_idx) && $stable(trap_addr)
                   && $stable(trap_be) && $stable(trap_is_read)));

endmodule

bind io_trap_unit io_trap_checker #(.N_ENTRY(N_ENTRY)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cyc_valid    (cyc_valid),
  .reg_addr     (reg_addr),
  .reg_rdata    (reg_rdata),
  .entry_hit    (entry_hit),
  .any_enabled  (any_enabled),
  .trap_req     (trap_req),
  .trap_idx     (trap_idx),
  .trap_addr    (trap_addr),
  .trap_be      (trap_be),
  .trap_is_read (trap_is_read)
);

// File: tb/io_trap_unit_tb_top.sv
`timescale 1ns/100ps
module io_trap_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cyc_valid = 1'b0;
  logic [15:0] cyc_addr = '0;
  logic [3:0]  cyc_be = '0;
  logic        cyc_is_read = 1'b0;
  logic        trap_req;
  logic [1:0]  trap_idx;
  logic [15:0] trap_addr;
  logic [3:0]  trap_be;
  logic        trap_is_read;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [63:0] mdl [4];
  logic [1:0]  e_idx;
  logic [15:0] e_addr;
  logic [3:0]  e_be;
  logic        e_rd;

  always #2.5 clk = ~clk;

  io_trap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_valid(cyc_valid),
    .cyc_addr(cyc_addr), .cyc_be(cyc_be), .cyc_is_read(cyc_is_read),
    .trap_req(trap_req), .trap_idx(trap_idx), .trap_addr(trap_addr),
    .trap_be(trap_be), .trap_is_read(trap_is_read)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench view of one entry, written bit by bit
  function automatic bit mdl_match(int e, logic [15:0] a, logic [3:0] be, bit rd);
    logic [63:0] r;
    r = mdl[e];
    if (!r[0]) return 0;
    for (int b = 2; b < 16; b++) begin
      if (b <= 7 && r[18 + b - 2]) continue;
      if (a[b] != r[b]) return 0;
    end
    for (int l = 0; l < 4; l++) begin
      if (r[36 + l]) continue;
      if (be[l] != r[32 + l]) return 0;
    end
    if (!r[49] && (r[48] != rd)) return 0;
    return 1;
  endfunction

  task automatic reg_wr(int word, logic [31:0] d);
    reg_addr  = 3'(word);
    reg_wdata = d;
    reg_wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (word % 2 == 1) mdl[word/2][63:32] = d & 32'h0003_00FF;
    else               mdl[word/2][31:0]  = d & 32'h00FC_FFFD;
  endtask

  task automatic reg_chk(int word, string req);
    logic [31:0] exp;
    reg_addr = 3'(word);
    #1;
    exp = (word % 2 == 1) ? mdl[word/2][63:32] : mdl[word/2][31:0];
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic entry(int e, logic [15:0] a, logic [5:0] am, logic [3:0] be,
                       logic [3:0] bem, bit rd, bit any, bit en);
    reg_wr(2*e,   {8'h0, am, 2'b0, a[15:2], 1'b0, en});
    reg_wr(2*e+1, {14'h0, any, rd, 8'h0, bem, be});
  endtask

  // drive one cycle; the registered result appears after the next rising edge
  task automatic cyc(logic [15:0] a, logic [3:0] be, bit rd, bit v, string req);
    int hit;
    cyc_addr = a; cyc_be = be; cyc_is_read = rd; cyc_valid = v;
    hit = -1;
    for (int e = 3; e >= 0; e--) if (mdl_match(e, a, be, rd)) hit = e;
    if (!v) hit = -1;
    @(posedge clk);
    @(negedge clk);
    cyc_valid = 1'b0;
    if (hit >= 0) begin
      e_idx = 2'(hit); e_addr = a; e_be = be; e_rd = rd;
    end
    chk(trap_req == (hit >= 0), req, 64'(trap_req), 64'(hit >= 0));
    chk(trap_idx == e_idx && trap_addr == e_addr && trap_be == e_be &&
        trap_is_read == e_rd, {req, "/R10"},
        {trap_idx, trap_addr, trap_be, trap_is_read},
        {e_idx, e_addr, e_be, e_rd});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    for (int e = 0; e < 4; e++) mdl[e] = '0;
    e_idx = '0; e_addr = '0; e_be = '0; e_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents and idle output
    for (int w = 0; w < 8; w++) reg_chk(w, "R1");
    chk(trap_req == 1'b0, "R1", 64'(trap_req), 0);
    cyc(16'h0000, 4'h0, 1'b0, 1'b1, "R1/R3");

    // R2: reserved bits
    reg_wr(0, 32'hFFFF_FFFF); reg_chk(0, "R2");
    chk(reg_rdata == 32'h00FC_FFFD, "R2", reg_rdata, 32'h00FC_FFFD);
    reg_wr(1, 32'hFFFF_FFFF); reg_chk(1, "R2");
    chk(reg_rdata == 32'h0003_00FF, "R2", reg_rdata, 32'h0003_00FF);
    reg_chk(2, "R2");

    // entry 0: 0x1230, be 0011, reads only
    entry(0, 16'h1230, 6'h00, 4'b0011, 4'b0000, 1'b1, 1'b0, 1'b1);
    cyc(16'h1233, 4'b0011, 1'b1, 1'b1, "R4");
    cyc(16'h1234, 4'b0011, 1'b1, 1'b1, "R4");
    cyc(16'h1230, 4'b0011, 1'b0, 1'b1, "R7");
    cyc(16'h1230, 4'b0111, 1'b1, 1'b1, "R6");
    cyc(16'h1230, 4'b0011, 1'b1, 1'b0, "R8");
    cyc(16'h1231, 4'b0011, 1'b1, 1'b1, "R8");
    cyc(16'h1231, 4'b0011, 1'b1, 1'b0, "R8");

    // R5: wildcard address bits 3:2
    entry(0, 16'h1230, 6'h03, 4'b0011, 4'b0000, 1'b1, 1'b0, 1'b1);
    cyc(16'h123C, 4'b0011, 1'b1, 1'b1, "R5");
    cyc(16'h1240, 4'b0011, 1'b1, 1'b1, "R5");
    entry(0, 16'h1200, 6'h3F, 4'b0011, 4'b0000, 1'b1, 1'b0, 1'b1);
    cyc(16'h12FC, 4'b0011, 1'b1, 1'b1, "R5");
    cyc(16'h13FC, 4'b0011, 1'b1, 1'b1, "R5");

    // R6: lane 2 wildcard
    entry(0, 16'h1230, 6'h00, 4'b0011, 4'b0100, 1'b1, 1'b0, 1'b1);
    cyc(16'h1230, 4'b0111, 1'b1, 1'b1, "R6");
    cyc(16'h1230, 4'b1011, 1'b1, 1'b1, "R6");

    // R7: write-only, then both
    entry(0, 16'h1230, 6'h00, 4'b0011, 4'b0000, 1'b0, 1'b0, 1'b1);
    cyc(16'h1230, 4'b0011, 1'b0, 1'b1, "R7");
    cyc(16'h1230, 4'b0011, 1'b1, 1'b1, "R7");
    entry(0, 16'h1230, 6'h00, 4'b0011, 4'b0000, 1'b0, 1'b1, 1'b1);
    cyc(16'h1230, 4'b0011, 1'b1, 1'b1, "R7");

    // R3: disabled entry, captured values held
    entry(0, 16'h1230, 6'h00, 4'b0011, 4'b0000, 1'b0, 1'b1, 1'b0);
    cyc(16'h1230, 4'b0011, 1'b1, 1'b1, "R3");

    // R9: entries 1..3 overlap
    entry(3, 16'h0400, 6'h3F, 4'b0000, 4'b1111, 1'b0, 1'b1, 1'b1);
    entry(2, 16'h0410, 6'h00, 4'b0001, 4'b0000, 1'b0, 1'b1, 1'b1);
    cyc(16'h0410, 4'b0001, 1'b0, 1'b1, "R9");
    entry(1, 16'h0410, 6'h00, 4'b0001, 4'b1110, 1'b1, 1'b0, 1'b1);
    cyc(16'h0412, 4'b0011, 1'b1, 1'b1, "R9");
    cyc(16'h0414, 4'b0001, 1'b0, 1'b1, "R9");

    // random phase
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 9) == 0) begin
        int w;
        w = $urandom_range(0, 7);
        reg_wr(w, $urandom() | ((w % 2 == 0) ? 32'h1 : 32'h0));
        reg_chk(w, "R2");
      end else begin
        logic [15:0] a;
        a = (mdl[$urandom_range(0, 3)][15:0] & 16'hFFFC) ^ 16'($urandom_range(0, 255));
        if ($urandom_range(0, 3) == 0) a = 16'($urandom());
        cyc(a, 4'($urandom()), 1'($urandom()), ($urandom_range(0, 7) != 0), "R8");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule